// File: doc/BRIEF.md
# Scanning A/D Acquisition Controller

This block sits between a 16-bit register bus and an external analog converter. Software sets the first and last channel of a scan window and a gain code for each channel, then chooses which start sources may launch a conversion: a write to the data offset, a pacer tick (optionally qualified by an external gate level), or an external trigger pulse. Each accepted start makes the sequencer issue one conversion request with the channel number and that channel's gain code. The 12-bit result comes back with the channel number in the top nibble and goes into a sample FIFO.

Software drains the FIFO by reading the data offset. The status word reports empty, half-full, a latched full (overrun) flag, a pending interrupt and a latched error for starts that arrived while the converter was still busy. The interrupt can be raised for every stored sample or only when the FIFO fill level reaches half its depth. A full FIFO discards new samples and keeps the old ones.

The sequencer has four states. SQ_IDLE goes to SQ_REQ when a start is accepted. SQ_REQ always goes to SQ_WAIT after one cycle. SQ_WAIT stays put until the converter signals done, then goes to SQ_STORE. SQ_STORE always returns to SQ_IDLE after one cycle.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset the status word (offset 6) reads 0x0100, `irq` is low, `conv_req` is low and every gain entry reads 0.
- R2: A write to offset 6 loads the control bits from wdata[6:0]: bit0 software start, bit1 pacer, bit2 external trigger, bit3 gate qualify, bit4 interrupt enable, bit5 half-full interrupt mode, bit6 counter clock select. Status bits [6:0] echo them. Bit 8 is empty, bit 9 is half, bit 10 is latched full, bit 11 is interrupt pending and bit 12 is the busy-drop error. The other bits read 0.
- R3: A start is accepted on any of these: a write to offset 0 with bit0 set; `pacer_tick` with bit1 set, and with `ext_gate` high when bit3 is set; `ext_trig` with bit2 set. A start from a disabled source produces no conversion request.
- R4: The scan register at offset 4 reads back the word last written to it. Its low byte gives the first channel and its high byte the last channel, each in its low 4 bits. Conversions take channels from first up to last and then wrap to first. A write to this register makes the next conversion use first.
- R5: A read at offset 0 returns the oldest FIFO word, with the channel in bits 15:12 and the result in bits 11:0, and removes that word. A read of an empty FIFO returns 0 and removes nothing.
- R6: A write to offset 2 stores wdata[4:0] as the gain code of the channel held in the scan register's first field. Offset 2 reads back that channel's code. `conv_gain` carries the code of `conv_ch` while `conv_req` is high.
- R7: A start that arrives while a conversion is in progress is dropped and sets status bit 12. Bit 12 stays set until a write to offset 8.
- R8: Half-full is set when the fill level is at least half the depth. The full flag is set when the fill level reaches the depth and stays set, even after reads, until the FIFO is cleared. A sample that arrives while the FIFO is full is discarded.
- R9: A write to offset 9 empties the FIFO and clears the full flag. If a sample is stored in the same cycle, that sample is lost.
- R10: With bit4 set, the pending flag (status bit 11, output `irq`) sets on every stored sample when bit5 is 0. When bit5 is 1 it sets when the fill level rises to half. A write to offset 8 clears it; if a new event arrives in the same cycle, the flag stays set.
- R11: `conv_req` is high for exactly the one cycle after the clock edge that accepts a start. A result presented with `conv_done` at edge N is readable and counted in status from edge N+1 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; removes a FIFO word at offset 0 |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current offset (combinational) |
| pacer_tick | input | 1 | Pacer start pulse |
| ext_trig | input | 1 | External start pulse |
| ext_gate | input | 1 | Gate level that qualifies pacer ticks |
| conv_req | output | 1 | Conversion request, one cycle |
| conv_ch | output | 4 | Channel being converted |
| conv_gain | output | 5 | Gain code for conv_ch |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 12 | Converter result |
| irq | output | 1 | Interrupt request |

## Verification
A request is due one edge after the start is accepted. A result sampled with `conv_done` at edge N shows up in the FIFO word, the fill flags and the per-sample interrupt from edge N+1, and a read or clear takes effect at the edge that samples it. The bench model applies each of these updates at the same edge the design uses. Inputs change one nanosecond after a rising edge and the comparison happens at the falling edge, so every output has settled before it is checked. The drop error is tested by a second start while the sequencer waits. The full flag is tested by more conversions than the FIFO holds, followed by a read.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int ADDR_W = 4;
    localparam int CTL_W  = 7;

    localparam logic [ADDR_W-1:0] OFS_DATA = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_GAIN = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_SCAN = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_CSR  = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_ICLR = 4'd8;
    localparam logic [ADDR_W-1:0] OFS_FCLR = 4'd9;

    localparam int CB_SW    = 0;
    localparam int CB_PACER = 1;
    localparam int CB_EXT   = 2;
    localparam int CB_GATE  = 3;
    localparam int CB_IRQEN = 4;
    localparam int CB_HALF  = 5;
    localparam int CB_CLKSL = 6;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_WAIT,
        SQ_STORE
    } seq_state_e;
endpackage

// File: rtl/scan_fifo.sv
module scan_fifo #(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head,
    output logic              empty,
    output logic              half,
    output logic              full_seen,
    output logic              push_ok,
    output logic              half_cross
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wp, rp;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic              full_now, do_push, do_pop;

    always_comb begin
        full_now   = (cnt == FULL_CNT);
        do_push    = push && !full_now;
        do_pop     = pop && (cnt != '0);
        cnt_nxt    = cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        push_ok    = do_push && !clr;
        half_cross = !clr && (cnt < HALF_CNT) && (cnt_nxt >= HALF_CNT);
        empty      = (cnt == '0);
        half       = (cnt >= HALF_CNT);
        head       = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp        <= '0;
            rp        <= '0;
            cnt       <= '0;
            full_seen <= 1'b0;
        end else begin
            if (do_push) wp <= wp + PTR_W'(1);
            if (do_pop)  rp <= rp + PTR_W'(1);
            cnt <= cnt_nxt;
            if (cnt_nxt == FULL_CNT) full_seen <= 1'b1;
        end
    end

    AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (full_seen && !clr) |=> full_seen); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !full_seen)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full_now && push && !pop && !clr) |=> (cnt == FULL_CNT)); // R8
endmodule

// File: rtl/gain_bank.sv
module gain_bank #(
    parameter int CHAN_W = 4,
    parameter int GAIN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CHAN_W-1:0] wr_idx,
    input  logic [GAIN_W-1:0] wr_code,
    input  logic [CHAN_W-1:0] cv_idx,
    output logic [GAIN_W-1:0] cv_code,
    input  logic [CHAN_W-1:0] rb_idx,
    output logic [GAIN_W-1:0] rb_code
);
    localparam int NCH = 1 << CHAN_W;

    logic [GAIN_W-1:0] tbl [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_entry
        logic [GAIN_W-1:0] code_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                   code_q <= '0;
            else if (wr && (wr_idx == CHAN_W'(g)))        code_q <= wr_code;
        end
        assign tbl[g] = code_q;
    end

    assign cv_code = tbl[cv_idx];
    assign rb_code = tbl[rb_idx];
endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import adc_scan_pkg::*;
#(
    parameter int CHAN_W = 4,
    parameter int RES_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    scan_wr,
    input  logic [CHAN_W-1:0]       new_first,
    input  logic [CHAN_W-1:0]       first_ch,
    input  logic [CHAN_W-1:0]       last_ch,
    input  logic                    conv_done,
    input  logic [RES_W-1:0]        conv_data,
    input  logic                    err_clr,
    output logic                    conv_req,
    output logic [CHAN_W-1:0]       conv_ch,
    output logic                    store,
    output logic [CHAN_W+RES_W-1:0] store_word,
    output logic                    drop_err
);
    seq_state_e        state, state_nxt;
    logic [CHAN_W-1:0] cur_ch;
    logic [RES_W-1:0]  res_q;
    logic              take;

    assign take = (state == SQ_IDLE) && start;

    always_comb begin
        state_nxt = state;
        unique case (state)
            SQ_IDLE:  if (start) state_nxt = SQ_REQ;
            SQ_REQ:   state_nxt = SQ_WAIT;
            SQ_WAIT:  if (conv_done) state_nxt = SQ_STORE;
            SQ_STORE: state_nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        conv_req   = (state == SQ_REQ);
        store      = (state == SQ_STORE);
        store_word = {conv_ch, res_q};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ch   <= '0;
            conv_ch  <= '0;
            res_q    <= '0;
            drop_err <= 1'b0;
        end else begin
            if (take) conv_ch <= cur_ch;
            if (scan_wr)   cur_ch <= new_first;
            else if (take) cur_ch <= (cur_ch == last_ch) ? first_ch : cur_ch + CHAN_W'(1);
            if ((state == SQ_WAIT) && conv_done) res_q <= conv_data;
            if (start && (state != SQ_IDLE)) drop_err <= 1'b1;
            else if (err_clr)                drop_err <= 1'b0;
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req); // R11
    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_err && !err_clr) |=> drop_err); // R7
    AST_REQ_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_req) |-> $past(start)); // R3
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
#(
    parameter int FIFO_DEPTH = 1024,
    parameter int CHAN_W     = 4,
    parameter int GAIN_W     = 5,
    parameter int RES_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:0]        bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              pacer_tick,
    input  logic              ext_trig,
    input  logic              ext_gate,
    output logic              conv_req,
    output logic [CHAN_W-1:0] conv_ch,
    output logic [GAIN_W-1:0] conv_gain,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    output logic              irq
);
    localparam int WORD_W = CHAN_W + RES_W;

    logic [CTL_W-1:0]  ctrl_q;
    logic [15:0]       scan_q;
    logic              irq_pend;
    logic              wr_data, wr_gain, wr_scan, wr_csr, wr_iclr, wr_fclr, rd_data;
    logic              start;
    logic [CHAN_W-1:0] first_ch, last_ch;
    logic              store, drop_err;
    logic [WORD_W-1:0] store_word, head;
    logic              empty, half, full_seen, push_ok, half_cross, irq_ev;
    logic [GAIN_W-1:0] rb_gain;
    logic [15:0]       status;

    always_comb begin
        wr_data  = bus_wr && (bus_addr == OFS_DATA);
        wr_gain  = bus_wr && (bus_addr == OFS_GAIN);
        wr_scan  = bus_wr && (bus_addr == OFS_SCAN);
        wr_csr   = bus_wr && (bus_addr == OFS_CSR);
        wr_iclr  = bus_wr && (bus_addr == OFS_ICLR);
        wr_fclr  = bus_wr && (bus_addr == OFS_FCLR);
        rd_data  = bus_rd && (bus_addr == OFS_DATA);
        first_ch = scan_q[CHAN_W-1:0];
        last_ch  = scan_q[8 +: CHAN_W];
        start    = (wr_data && ctrl_q[CB_SW])
                || (pacer_tick && ctrl_q[CB_PACER] && (!ctrl_q[CB_GATE] || ext_gate))
                || (ext_trig && ctrl_q[CB_EXT]);
        irq_ev   = ctrl_q[CB_HALF] ? half_cross : push_ok;
        status   = {3'b000, drop_err, irq_pend, full_seen, half, empty, 1'b0, ctrl_q};
        irq      = irq_pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            scan_q   <= '0;
            irq_pend <= 1'b0;
        end else begin
            if (wr_csr)  ctrl_q <= bus_wdata[CTL_W-1:0];
            if (wr_scan) scan_q <= bus_wdata;
            if (irq_ev && ctrl_q[CB_IRQEN]) irq_pend <= 1'b1;
            else if (wr_iclr)               irq_pend <= 1'b0;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = empty ? 16'h0000 : 16'(head);
            OFS_GAIN: bus_rdata = 16'(rb_gain);
            OFS_SCAN: bus_rdata = scan_q;
            OFS_CSR:  bus_rdata = status;
            default:  bus_rdata = 16'h0000;
        endcase
    end

    scan_seq #(.CHAN_W(CHAN_W), .RES_W(RES_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .scan_wr    (wr_scan),
        .new_first  (bus_wdata[CHAN_W-1:0]),
        .first_ch   (first_ch),
        .last_ch    (last_ch),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .err_clr    (wr_iclr),
        .conv_req   (conv_req),
        .conv_ch    (conv_ch),
        .store      (store),
        .store_word (store_word),
        .drop_err   (drop_err)
    );

    gain_bank #(.CHAN_W(CHAN_W), .GAIN_W(GAIN_W)) u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_gain),
        .wr_idx  (first_ch),
        .wr_code (bus_wdata[GAIN_W-1:0]),
        .cv_idx  (conv_ch),
        .cv_code (conv_gain),
        .rb_idx  (first_ch),
        .rb_code (rb_gain)
    );

    scan_fifo #(.DEPTH(FIFO_DEPTH), .WORD_W(WORD_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (wr_fclr),
        .push       (store),
        .push_word  (store_word),
        .pop        (rd_data),
        .head       (head),
        .empty      (empty),
        .half       (half),
        .full_seen  (full_seen),
        .push_ok    (push_ok),
        .half_cross (half_cross)
    );

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctrl_q[CB_IRQEN])); // R10
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_iclr) |=> irq); // R10
endmodule

// File: tb/test_adc_scan_ctrl.sv
`timescale 1ns/1ps
module test_adc_scan_ctrl;
    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = 4'd6;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pacer_tick = 1'b0, ext_trig = 1'b0, ext_gate = 1'b0;
    logic        conv_req;
    logic [3:0]  conv_ch;
    logic [4:0]  conv_gain;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        irq;

    always #2.5 clk = ~clk;

    adc_scan_ctrl #(.FIFO_DEPTH(DEPTH)) i_adc_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .ext_gate(ext_gate),
        .conv_req(conv_req), .conv_ch(conv_ch), .conv_gain(conv_gain),
        .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // converter model: answers two falling edges after a request
    int lat = 0, pat = 5;
    always @(negedge clk) begin
        if (!rst_n) begin lat = 0; conv_done <= 1'b0; end
        else begin
            if (conv_done) conv_done <= 1'b0;
            if (conv_req) lat = 2;
            else if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    pat = (pat * 37 + 11) % 4096;
                    conv_data <= 12'(pat);
                    conv_done <= 1'b1;
                end
            end
        end
    end

    // reference model
    int          ph, m_first, m_last, m_cur, m_cch, m_res, osz, nsz;
    logic [6:0]  m_ctrl;
    logic [15:0] m_scan;
    logic [15:0] q[$];
    bit          m_full, m_pend, m_err, trig, fclr, iclr, acc, ev;
    int          gt[16];

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; m_cur = 0; m_cch = 0; m_res = 0; m_ctrl = 0; m_scan = 0;
            q.delete(); m_full = 0; m_pend = 0; m_err = 0;
            foreach (gt[i]) gt[i] = 0;
        end else begin
            m_first = m_scan[3:0];
            m_last  = m_scan[11:8];
            trig = (bus_wr && bus_addr == 0 && m_ctrl[0])
                || (pacer_tick && m_ctrl[1] && (!m_ctrl[3] || ext_gate))
                || (ext_trig && m_ctrl[2]);
            fclr = bus_wr && bus_addr == 9;
            iclr = bus_wr && bus_addr == 8;
            osz = q.size();
            acc = (ph == 3) && osz < DEPTH && !fclr;
            if (fclr) begin q.delete(); m_full = 0; end
            else begin
                if (bus_rd && bus_addr == 0 && osz > 0) void'(q.pop_front());
                if (ph == 3 && osz < DEPTH) q.push_back({m_cch[3:0], m_res[11:0]});
                if (q.size() == DEPTH) m_full = 1;
            end
            nsz = q.size();
            ev = m_ctrl[5] ? (!fclr && osz < HALF && nsz >= HALF) : acc;
            if (ev && m_ctrl[4]) m_pend = 1; else if (iclr) m_pend = 0;
            if (trig && ph != 0) m_err = 1; else if (iclr) m_err = 0;
            case (ph)
                0: if (trig) begin
                       m_cch = m_cur;
                       m_cur = (m_cur == m_last) ? m_first : (m_cur + 1) % 16;
                       ph = 1;
                   end
                1: ph = 2;
                2: if (conv_done) begin m_res = conv_data; ph = 3; end
                default: ph = 0;
            endcase
            if (bus_wr && bus_addr == 2) gt[m_first] = bus_wdata[4:0];
            if (bus_wr && bus_addr == 4) begin m_scan = bus_wdata; m_cur = bus_wdata[3:0]; end
            if (bus_wr && bus_addr == 6) m_ctrl = bus_wdata[6:0];
        end
    end

    function automatic int exp_status();
        return (int'(m_err) << 12) | (int'(m_pend) << 11) | (int'(m_full) << 10)
             | (int'(q.size() >= HALF) << 9) | (int'(q.size() == 0) << 8) | int'(m_ctrl);
    endfunction

    // per-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R11 conv_req", conv_req, ph == 1);
            if (ph == 1) begin
                chk("R4 conv_ch", conv_ch, m_cch);
                chk("R6 conv_gain", conv_gain, gt[m_cch]);
            end
            chk("R10 irq", irq, m_pend);
            case (bus_addr)
                4'd0: chk("R5 data read", bus_rdata, q.size() > 0 ? int'(q[0]) : 0);
                4'd2: chk("R6 gain read", bus_rdata, gt[m_scan[3:0]]);
                4'd4: chk("R4 scan read", bus_rdata, m_scan);
                4'd6: chk("R8 status", bus_rdata, exp_status());
                default: chk("R2 unused read", bus_rdata, 0);
            endcase
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_addr = 4'd6;
    endtask

    task automatic rd(input int a, output int v);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = 4'(a);
        @(negedge clk); v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; bus_addr = 4'd6;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic sw_conv();
        wr(0, 0);
        idle(7);
    endtask

    task automatic pulse_pacer();
        @(posedge clk); #1 pacer_tick = 1'b1;
        @(posedge clk); #1 pacer_tick = 1'b0;
        idle(7);
    endtask

    int v;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status", bus_rdata, 16'h0100);
        chk("R1 irq", irq, 0);
        chk("R1 conv_req", conv_req, 0);
        rd(2, v); chk("R1 gain entry", v, 0);

        wr(6, 16'h0001);
        rd(6, v); chk("R2 control echo", v & 16'h007F, 16'h0001);

        // gains for channels 2..5
        for (int c = 2; c <= 5; c++) begin
            wr(4, (c << 8) | c);
            wr(2, c + 16);
        end
        rd(2, v); chk("R6 gain readback", v, 21);
        wr(4, 16'h0502);
        wr(0, 0);
        @(negedge clk); chk("R11 request next cycle", conv_req, 1);
        chk("R6 gain with request", conv_gain, 18);
        idle(6);
        for (int k = 0; k < 5; k++) sw_conv();
        for (int k = 0; k < 6; k++) begin
            rd(0, v);
            chk("R4 scan order", v >> 12, 2 + (k % 4));
        end
        rd(0, v); chk("R5 empty read", v, 0);

        // busy drop
        wr(0, 0); wr(0, 0); idle(6);
        rd(6, v); chk("R7 drop error set", (v >> 12) & 1, 1);
        wr(8, 0);
        rd(6, v); chk("R7 drop error cleared", (v >> 12) & 1, 0);
        rd(0, v);

        // disabled sources
        wr(6, 16'h0000);
        wr(0, 0); pulse_pacer();
        @(posedge clk); #1 ext_trig = 1'b1; @(posedge clk); #1 ext_trig = 1'b0; idle(6);
        rd(6, v); chk("R3 disabled sources idle", v & 16'h0100, 16'h0100);

        // pacer with gate
        wr(6, 16'h000A);
        pulse_pacer();
        rd(6, v); chk("R3 gate low blocks", v & 16'h0100, 16'h0100);
        ext_gate = 1'b1;
        pulse_pacer();
        rd(6, v); chk("R3 gate high passes", v & 16'h0100, 16'h0000);
        rd(0, v);

        // external trigger
        wr(6, 16'h0004);
        @(posedge clk); #1 ext_trig = 1'b1; @(posedge clk); #1 ext_trig = 1'b0; idle(6);
        rd(0, v); chk("R3 external start stored", (v >> 12) >= 2 ? 1 : 0, 1);

        // per-sample interrupt
        wr(6, 16'h0011);
        sw_conv();
        chk("R10 per-sample irq", irq, 1);
        wr(8, 0);
        @(negedge clk); chk("R10 irq cleared", irq, 0);
        rd(0, v);

        // half-full interrupt
        wr(6, 16'h0031);
        for (int k = 0; k < HALF - 1; k++) sw_conv();
        chk("R10 below half no irq", irq, 0);
        sw_conv();
        chk("R10 half irq", irq, 1);
        wr(8, 0);

        // overrun
        wr(6, 16'h0001);
        for (int k = 0; k < HALF + 2; k++) sw_conv();
        rd(6, v); chk("R8 full flag", (v >> 10) & 1, 1);
        rd(0, v);
        rd(6, v); chk("R8 full stays after read", (v >> 10) & 1, 1);
        chk("R8 half after read", (v >> 9) & 1, 1);
        wr(9, 0);
        rd(6, v); chk("R9 cleared status", v, 16'h0101);
        rd(4, v); chk("R4 scan readback", v, 16'h0502);

        idle(4);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule